// File: doc/BRIEF.md
# Clock Output Parking Controller

This block sits between a set of free-running clock sources and the clock output pins of a clock generator. Each output is a gated copy of its own source. The gate closes in two cases. The first is a per-output enable bit that is cleared. The second is an accepted power-down request. In both cases the output stops at a low level without a shortened high pulse. Each gate is a latch that is transparent while its source clock is low, followed by an AND gate. A change of gate state therefore appears only during a low phase of that clock.

The power-down pin is active low and asynchronous. A two-flop synchronizer in the CPU-clock domain brings it in. The request is accepted only after two consecutive synchronized low samples. A timer in the reference-clock domain then drops the oscillator and VCO enables. On release, the timer raises the oscillator enable first and the VCO enable one reference cycle later. The outputs stay low for a programmable number of reference cycles so that the sources can settle, and then the gates open again. While reset is asserted, the gates follow a reset-default enable mask given as a parameter, not the enable input.

Top module: `clk_park_ctrl`

## Requirements
- R1: After `pd_ni` falls, it is sampled on CPU-clock (source index 0) rising edges through two synchronizer flops. The request is accepted on the fourth rising edge after the fall. Gated CPU output `clk_o[0]` therefore shows exactly four more rising edges and then stays low.
- R2: A low level on `pd_ni` that is captured by only one CPU-clock rising edge is ignored. No output stops toggling and `osc_en_o` does not fall.
- R3: Every output rises only together with its source and falls only together with its source, so every high pulse lasts a full source high phase. This holds both for power-down entry and for enable changes.
- R4: Once power-down is accepted and has reached the reference-clock domain, all outputs are held low, and `osc_en_o` and `vco_en_o` are both 0. Changes on `out_en_i` in this state have no effect on the outputs.
- R5: Outside power-down and reset, output k toggles when `out_en_i[k]` is 1 and is held low when it is 0.
- R6: After the request is released, `osc_en_o` rises while `vco_en_o` is still 0. `vco_en_o` rises on the next reference-clock (source index N_OUT-1) rising edge. All outputs remain low at the moment `osc_en_o` rises.
- R7: With `wake_len_i` = L, the outputs stay low for at least L reference cycles after `osc_en_o` rises. `clk_o[0]` toggles again no later than L+3 reference cycles after that rise.
- R8: While `rst_ni` is 0, outputs follow the `DEFAULT_EN` mask (all ones by default) regardless of `out_en_i`, and `osc_en_o` and `vco_en_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src_i | input | N_OUT | Free-running source clocks; index 0 is the CPU clock, index N_OUT-1 the reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Asynchronous active-low power-down request |
| out_en_i | input | N_OUT | Per-output enable, 1 = clocking, 0 = parked low |
| wake_len_i | input | CNT_W | Stabilization interval in reference cycles |
| clk_o | output | N_OUT | Gated output clocks |
| osc_en_o | output | 1 | Oscillator enable |
| vco_en_o | output | 1 | Synthesizer VCO enable |

## Verification
The per-output enable and the power-down gate drive the same latch input. Both can therefore change in the same CPU cycle. The bench provokes this by clearing half of the enable bits at the same moment it pulls the power-down pin low. It then judges two things. The CPU output must still show exactly four rising edges before it parks. A monitor of every output's high-pulse width must record no shortened pulse on any output. A later enable change made while powered down must leave all outputs silent until the wake interval ends.

// File: rtl/clk_park_pkg.sv
package clk_park_pkg;

    typedef enum logic [1:0] {
        WK_RUN  = 2'd0,
        WK_DOWN = 2'd1,
        WK_WAKE = 2'd2
    } wake_state_e;

    typedef struct packed {
        logic s1;
        logic s2;
        logic low1;
        logic acc;
    } pd_det_t;

endpackage

// File: rtl/clk_park_pd_detect.sv
// Synchronizes the power-down pin and accepts it after two low samples.
module clk_park_pd_detect
    import clk_park_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pd_ni,
    output logic pd_acc_o
);

    pd_det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.s1   = pd_ni;
        det_d.s2   = det_q.s1;
        det_d.low1 = ~det_q.s2;
        det_d.acc  = det_q.low1 & ~det_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            det_q <= '{s1: 1'b1, s2: 1'b1, low1: 1'b0, acc: 1'b0};
        end else begin
            det_q <= det_d;
        end
    end

    assign pd_acc_o = det_q.acc;

endmodule

// File: rtl/clk_park_wake_timer.sv
// Reference-domain sequencer: drops oscillator/VCO enables and times wake-up.
module clk_park_wake_timer
    import clk_park_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pd_acc_i,
    input  logic [CNT_W-1:0] wake_len_i,
    output logic             osc_en_o,
    output logic             vco_en_o,
    output logic             hold_o,
    output wake_state_e      state_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             r1;
        logic             r2;
        wake_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic             osc;
        logic             vco;
        logic             hold;
    } wake_reg_t;

    wake_reg_t wk_d, wk_q;

    always_comb begin
        wk_d    = wk_q;
        wk_d.r1 = pd_acc_i;
        wk_d.r2 = wk_q.r1;
        unique case (wk_q.st)
            WK_RUN: begin
                if (wk_q.r2) begin
                    wk_d.st   = WK_DOWN;
                    wk_d.osc  = 1'b0;
                    wk_d.vco  = 1'b0;
                    wk_d.hold = 1'b1;
                end
            end
            WK_DOWN: begin
                if (!wk_q.r2) begin
                    wk_d.st  = WK_WAKE;
                    wk_d.osc = 1'b1;
                    wk_d.cnt = wake_len_i;
                end
            end
            WK_WAKE: begin
                if (wk_q.r2) begin
                    wk_d.st  = WK_DOWN;
                    wk_d.osc = 1'b0;
                    wk_d.vco = 1'b0;
                end else begin
                    wk_d.vco = 1'b1;
                    if (wk_q.cnt == '0) begin
                        wk_d.st   = WK_RUN;
                        wk_d.hold = 1'b0;
                    end else begin
                        wk_d.cnt = wk_q.cnt - CNT_ONE;
                    end
                end
            end
            default: begin
                wk_d.st = WK_RUN;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wk_q <= '{r1: 1'b0, r2: 1'b0, st: WK_RUN, cnt: '0,
                      osc: 1'b1, vco: 1'b1, hold: 1'b0};
        end else begin
            wk_q <= wk_d;
        end
    end

    assign osc_en_o = wk_q.osc;
    assign vco_en_o = wk_q.vco;
    assign hold_o   = wk_q.hold;
    assign state_o  = wk_q.st;

endmodule

// File: rtl/clk_park_gate.sv
// Low-transparent latch plus AND: the enable can only change while the clock is low.
module clk_park_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic clk_o
);

    logic en_l;

    always_latch begin
        if (!clk_i) begin
            en_l <= en_i;
        end
    end

    assign clk_o = clk_i & en_l;

endmodule

// File: rtl/clk_park_ctrl.sv
module clk_park_ctrl
    import clk_park_pkg::*;
#(
    parameter int unsigned       N_OUT      = 8,
    parameter int unsigned       CPU_IDX    = 0,
    parameter int unsigned       REF_IDX    = N_OUT - 1,
    parameter int unsigned       CNT_W      = 16,
    parameter logic [N_OUT-1:0]  DEFAULT_EN = '1
) (
    input  logic [N_OUT-1:0] clk_src_i,
    input  logic             rst_ni,
    input  logic             pd_ni,
    input  logic [N_OUT-1:0] out_en_i,
    input  logic [CNT_W-1:0] wake_len_i,
    output logic [N_OUT-1:0] clk_o,
    output logic             osc_en_o,
    output logic             vco_en_o
);

    logic             pd_acc;
    logic             wake_hold;
    wake_state_e      wake_st;
    logic             gate_allow;
    logic [N_OUT-1:0] en_eff;

    clk_park_pd_detect i_pd_detect (
        .clk_i    (clk_src_i[CPU_IDX]),
        .rst_ni   (rst_ni),
        .pd_ni    (pd_ni),
        .pd_acc_o (pd_acc)
    );

    clk_park_wake_timer #(
        .CNT_W (CNT_W)
    ) i_wake_timer (
        .clk_i      (clk_src_i[REF_IDX]),
        .rst_ni     (rst_ni),
        .pd_acc_i   (pd_acc),
        .wake_len_i (wake_len_i),
        .osc_en_o   (osc_en_o),
        .vco_en_o   (vco_en_o),
        .hold_o     (wake_hold),
        .state_o    (wake_st)
    );

    // Gates close as soon as the request is accepted; the wake hold keeps them
    // closed until the stabilization count has finished.
    always_comb begin
        gate_allow = ~pd_acc & ~wake_hold;
        en_eff     = (rst_ni ? out_en_i : DEFAULT_EN) & {N_OUT{gate_allow}};
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_gate
        clk_park_gate i_gate (
            .clk_i (clk_src_i[g]),
            .en_i  (en_eff[g]),
            .clk_o (clk_o[g])
        );
    end

endmodule

// File: rtl/clk_park_ctrl_chk.sv
module clk_park_ctrl_chk
    import clk_park_pkg::*;
#(
    parameter int unsigned N_OUT   = 8,
    parameter int unsigned CPU_IDX = 0,
    parameter int unsigned REF_IDX = N_OUT - 1
) (
    input logic [N_OUT-1:0] clk_src_i,
    input logic             rst_ni,
    input logic             pd_ni,
    input logic [N_OUT-1:0] clk_o,
    input logic             osc_en_o,
    input logic             vco_en_o,
    input logic             pd_acc,
    input wake_state_e      wake_st
);

    logic cpu_clk;
    logic ref_clk;
    assign cpu_clk = clk_src_i[CPU_IDX];
    assign ref_clk = clk_src_i[REF_IDX];

    // R1: acceptance needs two consecutive low samples
    p_accept_two_r1: assert property (@(posedge cpu_clk) disable iff (!rst_ni)
        $rose(pd_acc) |-> !$past(pd_ni, 3) && !$past(pd_ni, 4));

    // R2: a high sample three edges back forbids acceptance
    p_high_blocks_r2: assert property (@(posedge cpu_clk) disable iff (!rst_ni)
        $past(pd_ni, 3) |-> !pd_acc);

    // R4: enables off and outputs parked while powered down
    p_down_enables_r4: assert property (@(posedge ref_clk) disable iff (!rst_ni)
        (wake_st == WK_DOWN) |-> !osc_en_o && !vco_en_o);

    p_parked_r4: assert property (@(posedge ref_clk) disable iff (!rst_ni)
        (wake_st == WK_DOWN) && $past(wake_st == WK_DOWN) |-> clk_o == '0);

    // R6: oscillator enable leads the VCO enable
    p_osc_first_r6: assert property (@(posedge ref_clk) disable iff (!rst_ni)
        $rose(osc_en_o) |-> !vco_en_o);

    p_vco_after_r6: assert property (@(posedge ref_clk) disable iff (!rst_ni)
        $rose(vco_en_o) |-> osc_en_o);

    // R7: oscillator stays on through the wake interval
    p_wake_osc_r7: assert property (@(posedge ref_clk) disable iff (!rst_ni)
        (wake_st == WK_WAKE) |-> osc_en_o);

    // R3: outputs change only together with their sources
    for (genvar g = 0; g < N_OUT; g++) begin : g_runt
        always @(posedge clk_o[g]) begin
            p_no_runt_rise_r3: assert (clk_src_i[g] === 1'b1);
        end
        always @(negedge clk_o[g]) begin
            p_no_runt_fall_r3: assert (clk_src_i[g] === 1'b0);
        end
    end

endmodule

bind clk_park_ctrl clk_park_ctrl_chk #(
    .N_OUT   (N_OUT),
    .CPU_IDX (CPU_IDX),
    .REF_IDX (REF_IDX)
) i_chk (
    .clk_src_i (clk_src_i),
    .rst_ni    (rst_ni),
    .pd_ni     (pd_ni),
    .clk_o     (clk_o),
    .osc_en_o  (osc_en_o),
    .vco_en_o  (vco_en_o),
    .pd_acc    (pd_acc),
    .wake_st   (wake_st)
);

// File: tb/test_clk_park_ctrl.sv
`timescale 1ns/100ps
module test_clk_park_ctrl;

    localparam int N     = 8;
    localparam int CNT_W = 16;
    localparam int WLEN  = 20;
    localparam real REF_P = 14.0;
    localparam int NVEC  = 6;
    // each row: {enable stimulus, expected toggling mask}
    localparam logic [2*N-1:0] VEC [NVEC] = '{
        {8'hFF, 8'hFF}, {8'h00, 8'h00}, {8'hA5, 8'hA5},
        {8'h5A, 8'h5A}, {8'h0F, 8'h0F}, {8'h81, 8'h81}
    };

    logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
    logic c4 = 1'b0, c5 = 1'b0, c6 = 1'b0, c7 = 1'b0;
    always #2.5 c0 = ~c0;   // 200 MHz CPU clock
    always #2.5 c1 = ~c1;
    always #4.0 c2 = ~c2;
    always #5.0 c3 = ~c3;
    always #5.0 c4 = ~c4;
    always #10.0 c5 = ~c5;
    always #6.0 c6 = ~c6;
    always #7.0 c7 = ~c7;   // reference clock

    logic [N-1:0]     clk_src;
    logic             rst_n;
    logic             pd_n;
    logic [N-1:0]     out_en;
    logic [CNT_W-1:0] wake_len;
    logic [N-1:0]     clk_o;
    logic             osc_en;
    logic             vco_en;

    assign clk_src = {c7, c6, c5, c4, c3, c2, c1, c0};

    clk_park_ctrl i_clk_park_ctrl (
        .clk_src_i  (clk_src),
        .rst_ni     (rst_n),
        .pd_ni      (pd_n),
        .out_en_i   (out_en),
        .wake_len_i (wake_len),
        .clk_o      (clk_o),
        .osc_en_o   (osc_en),
        .vco_en_o   (vco_en)
    );

    function automatic real half_of(input int k);
        case (k)
            0, 1:    return 2.5;
            2:       return 4.0;
            3, 4:    return 5.0;
            5:       return 10.0;
            6:       return 6.0;
            default: return 7.0;
        endcase
    endfunction

    int      edges [N];
    int      snap  [N];
    realtime t_rise[N];
    int      runts = 0;
    int      osc_falls = 0;
    logic [N-1:0] prev_o = '0;
    int n_checks = 0;
    int n_err    = 0;

    // pulse monitor: counts rising edges and flags shortened high pulses
    always @(clk_o) begin
        for (int k = 0; k < N; k++) begin
            if (clk_o[k] === 1'b1 && prev_o[k] !== 1'b1) begin
                edges[k]++;
                t_rise[k] = $realtime;
            end
            if (clk_o[k] === 1'b0 && prev_o[k] === 1'b1) begin
                if (($realtime - t_rise[k]) < half_of(k) - 0.05 ||
                    ($realtime - t_rise[k]) > half_of(k) + 0.05)
                    runts++;
            end
        end
        prev_o = clk_o;
    end

    always @(negedge osc_en) osc_falls++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic take_snap();
        for (int k = 0; k < N; k++) snap[k] = edges[k];
    endtask

    function automatic int got(input int k);
        return edges[k] - snap[k];
    endfunction

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        #100000;
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_sim();
    end

    initial begin
        realtime t_osc;
        realtime t_run;
        int      s0;
        int      tmo;
        rst_n    = 1'b0;
        pd_n     = 1'b1;
        out_en   = '0;
        wake_len = CNT_W'(WLEN);

        // R8: reset default mask overrides enable input
        #50.3;
        take_snap();
        #200;
        for (int k = 0; k < N; k++)
            check(got(k) > 0, "R8 reset default toggling", got(k), 1);
        check(osc_en === 1'b1, "R8 osc_en in reset", int'(osc_en), 1);
        check(vco_en === 1'b1, "R8 vco_en in reset", int'(vco_en), 1);
        rst_n = 1'b1;
        #40;

        // R5: vector table of enable patterns
        for (int v = 0; v < NVEC; v++) begin
            out_en = VEC[v][2*N-1:N];
            #151.3;
            take_snap();
            #300;
            for (int k = 0; k < N; k++)
                check((got(k) > 0) == VEC[v][k], "R5 enable pattern",
                      int'(got(k) > 0), int'(VEC[v][k]));
        end

        // R2: single-sample low pulse is ignored
        out_en = '1;
        #100;
        @(posedge c0);
        #1 pd_n = 1'b0;
        #5 pd_n = 1'b1;
        #60;
        take_snap();
        #200;
        for (int k = 0; k < N; k++)
            check(got(k) > 0, "R2 glitch ignored", got(k), 1);
        check(osc_falls == 0, "R2 osc_en kept", osc_falls, 0);

        // R1 with simultaneous enable change: accept on fourth edge
        @(posedge c0);
        #1;
        pd_n   = 1'b0;
        out_en = 8'h0F;
        take_snap();
        #100;
        check(got(0) == 4, "R1 cpu edges before park", got(0), 4);

        // R4: parked, enables dropped, enable input ignored
        #300;
        out_en = '1;
        take_snap();
        #200;
        for (int k = 0; k < N; k++)
            check(got(k) == 0, "R4 outputs parked", got(k), 0);
        check(osc_en === 1'b0, "R4 osc_en off", int'(osc_en), 0);
        check(vco_en === 1'b0, "R4 vco_en off", int'(vco_en), 0);

        // R6/R7: release and wake sequence
        @(posedge c0);
        #1 pd_n = 1'b1;
        take_snap();
        tmo = 0;
        while (osc_en !== 1'b1 && tmo < 500) begin
            #1;
            tmo++;
        end
        t_osc = $realtime;
        check(osc_en === 1'b1, "R6 osc_en returns", int'(osc_en), 1);
        check(vco_en === 1'b0, "R6 vco_en after osc", int'(vco_en), 0);
        for (int k = 0; k < N; k++)
            check(got(k) == 0, "R6 held at osc rise", got(k), 0);
        #15;
        check(vco_en === 1'b1, "R6 vco_en one ref cycle later", int'(vco_en), 1);
        #235;
        for (int k = 0; k < N; k++)
            check(got(k) == 0, "R7 held during wake", got(k), 0);
        s0  = edges[0];
        tmo = 0;
        while (edges[0] == s0 && tmo < 500) begin
            #1;
            tmo++;
        end
        t_run = $realtime;
        check((t_run - t_osc) >= WLEN * REF_P, "R7 minimum hold (ns)",
              int'(t_run - t_osc), int'(WLEN * REF_P));
        check((t_run - t_osc) <= (WLEN + 3) * REF_P, "R7 maximum hold (ns)",
              int'(t_run - t_osc), int'((WLEN + 3) * REF_P));
        #50;
        take_snap();
        #200;
        for (int k = 0; k < N; k++)
            check(got(k) > 0, "R7 outputs resumed", got(k), 1);

        // R3: no shortened pulse anywhere in the run
        check(runts == 0, "R3 shortened pulses", runts, 0);
        finish_sim();
    end

endmodule